// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching descriptors from memory: one word from a context table, then up to three levels of page tables. A walk stops as soon as it meets a leaf descriptor, so a translation covers a 16 MiB, 256 KiB or 4 KiB page depending on the level where the leaf sits. A failed walk returns a fault code that records both the fault kind and the level that failed. On a successful walk the walker keeps the leaf's referenced and modified flags current by writing the leaf back to memory when they change.

A requester presents one request at a time on a valid/ready handshake and waits for a one-cycle `done` pulse; the result stays on the response outputs until the next request is accepted. Table reads and the flag write-back go through a single 32-bit memory master with a valid/ready handshake and a per-read error flag. A bypass request skips translation entirely. A bypass instruction fetch with boot mode set is steered into a boot ROM window.

The controller is a five-state machine. `ST_IDLE` accepts a request. It goes to `ST_READ` for a walk, or to `ST_DONE` for a bypass. `ST_READ` holds a table read until the memory accepts it. It moves to `ST_CHECK`, or to `ST_DONE` on a bus error. `ST_CHECK` decodes the fetched descriptor. A pointer sends it back to `ST_READ` one level deeper. A leaf whose flags need updating sends it to `ST_WRITE`. Any other leaf, and any fault, sends it to `ST_DONE`. `ST_WRITE` holds the write-back until it is accepted and then moves to `ST_DONE`. `ST_DONE` pulses `done` and returns to `ST_IDLE`.

Top module: `pgwalk`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is accepted only when `req_valid` and `req_ready` are both high, and `req_valid` is ignored at all other times. Every accepted request produces exactly one `done` pulse, one cycle long, and the response outputs keep their values until the next request is accepted.
- R2: The first memory read of a walk is at address (`cfg_ctx_ptr` << 4) + (`cfg_ctx_num` << 2).
- R3: Bits 1:0 of a descriptor give its kind: 0 = invalid, 1 = pointer, 2 = leaf, 3 = reserved. The next table read after a pointer found at level k is at ((descriptor with bits 1:0 cleared) << 4) + (index << 2). The index is vaddr[31:24] for level 1, vaddr[23:18] for level 2 and vaddr[17:12] for level 3. The context-table entry counts as level 0.
- R4: A leaf at level 1 gives `rsp_size` = 2 (16 MiB) and `rsp_paddr` = ({descriptor[31:8], 12'h000}) + vaddr[23:0].
- R5: A leaf at level 2 gives `rsp_size` = 1 and adds vaddr[17:0]. A leaf at level 3 gives `rsp_size` = 0 and adds vaddr[11:0].
- R6: An invalid descriptor at level L ends the walk with `rsp_fault` = (L << 8) | (1 << 2).
- R7: Each of these ends the walk with `rsp_fault` = (L << 8) | (4 << 2): a reserved descriptor at level L, a leaf in the context table (L = 0), or a pointer at level 3.
- R8: A read that returns `mem_err` ends the walk with fault kind 4 at the level being read, and no further memory access follows.
- R9: On a successful walk, the leaf is written back to its own address if its referenced flag (bit 5) is clear, or if the access is a write and its modified flag (bit 6) is clear. The written value sets bit 5, and also sets bit 6 on a write. No write happens when no flag changes or when the walk faults. `done` follows the completed write.
- R10: A bypass request makes no memory access and returns fault 0 and size 0. `rsp_paddr` is the zero-extended vaddr, except for an instruction fetch with `cfg_boot` set, which returns `cfg_prom_base` OR vaddr[18:0].
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R12: A successful walk returns `rsp_fault` = 0. A fault code only ever has bits in positions 9:8 and 4:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_bypass | input | 1 | Physical mode: skip translation |
| cfg_ctx_ptr | input | 32 | Context table pointer (in units of 16 bytes) |
| cfg_ctx_num | input | CTX_W | Current context number |
| cfg_boot | input | 1 | Boot mode: bypass fetches go to the ROM window |
| cfg_prom_base | input | 36 | Base address of the boot ROM window |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access; read data and error are valid |
| mem_write | output | 1 | Access is a write-back |
| mem_addr | output | 36 | Byte address of the descriptor |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Read ended in a bus error |
| done | output | 1 | One-cycle completion pulse |
| rsp_paddr | output | 36 | Translated physical address |
| rsp_size | output | 2 | Page size: 0 = 4 KiB, 1 = 256 KiB, 2 = 16 MiB |
| rsp_fault | output | 10 | Fault code: level in bits 9:8, kind in bits 4:2, 0 on success |

## Verification
Several properties are checked on every cycle: the `done` pulse is one cycle long, the memory port is silent while idle and during a bypass, a memory access is held steady until it is accepted, every write-back carries the referenced flag, a bus error stops all further memory traffic, and a fault code never sets bits outside its level and kind fields. Only the directed scenarios can show that the values are right. This covers the exact descriptor addresses at each level, the physical address and size for each leaf depth, the level and kind for each fault cause, whether a write-back happens and what it contains, and the ROM redirection in boot mode.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
    localparam int PA_W  = 36;
    localparam int FLT_W = 10;

    localparam logic [1:0] ET_INVALID = 2'd0;
    localparam logic [1:0] ET_TABLE   = 2'd1;
    localparam logic [1:0] ET_LEAF    = 2'd2;
    localparam logic [1:0] ET_RSVD    = 2'd3;

    localparam int REF_BIT = 5;
    localparam int MOD_BIT = 6;

    localparam logic [2:0] FT_NONE    = 3'd0;
    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_XLATE   = 3'd4;

    localparam logic [1:0] SZ_4K   = 2'd0;
    localparam logic [1:0] SZ_256K = 2'd1;
    localparam logic [1:0] SZ_16M  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK,
        ST_WRITE,
        ST_DONE
    } pw_state_e;

    typedef enum logic [1:0] {
        ACT_DESCEND,
        ACT_LEAF,
        ACT_FAULT
    } pw_act_e;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr
    import pgwalk_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [1:0]       tbl_lvl,
    input  logic [1:0]       leaf_lvl,
    input  logic [31:2]      ptr_field,
    input  logic [31:8]      page_field,
    input  logic [31:0]      vaddr,
    input  logic [31:0]      ctx_ptr,
    input  logic [CTX_W-1:0] ctx_num,
    output logic [PA_W-1:0]  tbl_addr,
    output logic [PA_W-1:0]  leaf_paddr
);
    localparam int CTX_PAD = PA_W - CTX_W - 2;

    logic [PA_W-1:0] tbl_base;
    logic [PA_W-1:0] page_base;
    logic [PA_W-1:0] index_off;
    logic [PA_W-1:0] page_off;

    assign tbl_base  = {ptr_field, 2'b00, 4'h0};
    assign page_base = {page_field, 12'h000};

    // descriptor slot within the table selected by the walk level
    always_comb begin
        index_off = '0;
        unique case (tbl_lvl)
            2'd1:    index_off = {{(PA_W-10){1'b0}}, vaddr[31:24], 2'b00};
            2'd2:    index_off = {{(PA_W-8){1'b0}},  vaddr[23:18], 2'b00};
            2'd3:    index_off = {{(PA_W-8){1'b0}},  vaddr[17:12], 2'b00};
            default: index_off = '0;
        endcase
    end

    always_comb begin
        if (tbl_lvl == 2'd0) begin
            tbl_addr = {ctx_ptr, 4'h0} + {{CTX_PAD{1'b0}}, ctx_num, 2'b00};
        end else begin
            tbl_addr = tbl_base + index_off;
        end
    end

    // untranslated offset grows as the leaf sits higher in the tree
    always_comb begin
        page_off = '0;
        unique case (leaf_lvl)
            2'd1:    page_off = {{(PA_W-24){1'b0}}, vaddr[23:0]};
            2'd2:    page_off = {{(PA_W-18){1'b0}}, vaddr[17:0]};
            default: page_off = {{(PA_W-12){1'b0}}, vaddr[11:0]};
        endcase
    end

    assign leaf_paddr = page_base + page_off;
endmodule

// File: rtl/pgwalk_eval.sv
module pgwalk_eval
    import pgwalk_pkg::*;
(
    input  logic [31:0] entry,
    input  logic [1:0]  lvl,
    input  logic        is_write,
    output pw_act_e     act,
    output logic [2:0]  ftype,
    output logic [1:0]  size,
    output logic        need_wb,
    output logic [31:0] wb_data
);
    always_comb begin
        act   = ACT_FAULT;
        ftype = FT_XLATE;
        unique case (entry[1:0])
            ET_INVALID: begin
                act   = ACT_FAULT;
                ftype = FT_INVALID;
            end
            ET_TABLE: begin
                if (lvl == 2'd3) begin
                    act   = ACT_FAULT;
                    ftype = FT_XLATE;
                end else begin
                    act   = ACT_DESCEND;
                    ftype = FT_NONE;
                end
            end
            ET_LEAF: begin
                if (lvl == 2'd0) begin
                    act   = ACT_FAULT;
                    ftype = FT_XLATE;
                end else begin
                    act   = ACT_LEAF;
                    ftype = FT_NONE;
                end
            end
            default: begin
                act   = ACT_FAULT;
                ftype = FT_XLATE;
            end
        endcase
    end

    always_comb begin
        unique case (lvl)
            2'd1:    size = SZ_16M;
            2'd2:    size = SZ_256K;
            default: size = SZ_4K;
        endcase
    end

    always_comb begin
        wb_data          = entry;
        wb_data[REF_BIT] = 1'b1;
        if (is_write) begin
            wb_data[MOD_BIT] = 1'b1;
        end
    end

    assign need_wb = !entry[REF_BIT] || (is_write && !entry[MOD_BIT]);
endmodule

// File: rtl/pgwalk.sv
module pgwalk
    import pgwalk_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic              req_bypass,
    input  logic [31:0]       cfg_ctx_ptr,
    input  logic [CTX_W-1:0]  cfg_ctx_num,
    input  logic              cfg_boot,
    input  logic [35:0]       cfg_prom_base,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [35:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    output logic              done,
    output logic [35:0]       rsp_paddr,
    output logic [1:0]        rsp_size,
    output logic [9:0]        rsp_fault
);
    localparam int ROM_W = 19;

    pw_state_e         state_q, state_d;
    logic [31:0]       vaddr_q;
    logic              wr_q;
    logic              byp_q;
    logic [1:0]        lvl_q;
    logic [31:0]       entry_q;
    logic [PA_W-1:0]   tbl_addr_q;
    logic [31:0]       wb_q;

    logic [1:0]        tbl_lvl;
    logic [PA_W-1:0]   tbl_addr_c;
    logic [PA_W-1:0]   leaf_paddr_c;
    pw_act_e           act_c;
    logic [2:0]        ftype_c;
    logic [1:0]        size_c;
    logic              need_wb_c;
    logic [31:0]       wb_data_c;
    logic              accept;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign tbl_lvl = (state_q == ST_IDLE) ? 2'd0 : (lvl_q + 2'd1);

    pgwalk_addr #(.CTX_W(CTX_W)) u_addr (
        .tbl_lvl    (tbl_lvl),
        .leaf_lvl   (lvl_q),
        .ptr_field  (entry_q[31:2]),
        .page_field (entry_q[31:8]),
        .vaddr      (vaddr_q),
        .ctx_ptr    (cfg_ctx_ptr),
        .ctx_num    (cfg_ctx_num),
        .tbl_addr   (tbl_addr_c),
        .leaf_paddr (leaf_paddr_c)
    );

    pgwalk_eval u_eval (
        .entry    (entry_q),
        .lvl      (lvl_q),
        .is_write (wr_q),
        .act      (act_c),
        .ftype    (ftype_c),
        .size     (size_c),
        .need_wb  (need_wb_c),
        .wb_data  (wb_data_c)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = req_bypass ? ST_DONE : ST_READ;
                end
            end
            ST_READ: begin
                if (mem_ready) begin
                    state_d = mem_err ? ST_DONE : ST_CHECK;
                end
            end
            ST_CHECK: begin
                unique case (act_c)
                    ACT_DESCEND: state_d = ST_READ;
                    ACT_LEAF:    state_d = need_wb_c ? ST_WRITE : ST_DONE;
                    default:     state_d = ST_DONE;
                endcase
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_valid = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_write = (state_q == ST_WRITE);
        mem_addr  = tbl_addr_q;
        mem_wdata = wb_q;
        done      = (state_q == ST_DONE);
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q    <= '0;
            wr_q       <= 1'b0;
            byp_q      <= 1'b0;
            lvl_q      <= '0;
            entry_q    <= '0;
            tbl_addr_q <= '0;
            wb_q       <= '0;
            rsp_paddr  <= '0;
            rsp_size   <= SZ_4K;
            rsp_fault  <= '0;
        end else begin
            if (accept) begin
                vaddr_q   <= req_vaddr;
                wr_q      <= req_write;
                byp_q     <= req_bypass;
                lvl_q     <= 2'd0;
                rsp_size  <= SZ_4K;
                rsp_fault <= '0;
                if (req_bypass) begin
                    if (cfg_boot && req_fetch) begin
                        rsp_paddr <= cfg_prom_base |
                                     {{(PA_W-ROM_W){1'b0}}, req_vaddr[ROM_W-1:0]};
                    end else begin
                        rsp_paddr <= {{(PA_W-32){1'b0}}, req_vaddr};
                    end
                end else begin
                    rsp_paddr  <= '0;
                    tbl_addr_q <= tbl_addr_c;
                end
            end
            if ((state_q == ST_READ) && mem_ready) begin
                if (mem_err) begin
                    rsp_fault <= {lvl_q, 3'b000, FT_XLATE, 2'b00};
                end else begin
                    entry_q <= mem_rdata;
                end
            end
            if (state_q == ST_CHECK) begin
                unique case (act_c)
                    ACT_DESCEND: begin
                        lvl_q      <= lvl_q + 2'd1;
                        tbl_addr_q <= tbl_addr_c;
                    end
                    ACT_LEAF: begin
                        rsp_paddr <= leaf_paddr_c;
                        rsp_size  <= size_c;
                        rsp_fault <= '0;
                        wb_q      <= wb_data_c;
                    end
                    default: begin
                        rsp_fault <= {lvl_q, 3'b000, ftype_c, 2'b00};
                    end
                endcase
            end
        end
    end

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_valid);

    // R10
    bypass_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_q && !req_ready) |-> !mem_valid);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                       $stable(mem_write) && $stable(mem_wdata)));

    // R9
    wb_sets_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write) |-> mem_wdata[REF_BIT]);

    // R8
    err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_write && mem_err) |=> (done && !mem_valid));

    // R12
    fault_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rsp_fault[7:5] == 3'b000 && rsp_fault[1:0] == 2'b00));
endmodule

// File: tb/pgwalk_bench.sv
module pgwalk_bench;
    localparam int CLK_P = 10;
    localparam logic [31:0] CTX_PTR = 32'h0000_0100;
    localparam logic [7:0]  CTX_NUM = 8'd3;
    localparam logic [35:0] PROM    = 36'h0_FF00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0, req_fetch = 1'b0, req_bypass = 1'b0;
    logic        cfg_boot = 1'b0;
    logic        mem_valid, mem_ready, mem_write, mem_err;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        done;
    logic [35:0] rsp_paddr;
    logic [1:0]  rsp_size;
    logic [9:0]  rsp_fault;

    logic [31:0] mem [4096];
    logic        err_on = 1'b0;
    logic [35:0] err_addr = '0;
    logic        tog = 1'b0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [35:0] last_rd_addr = '0, first_rd_addr = '0, last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;
    int          n_chk = 0, n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pgwalk #(.CTX_W(8)) u_pgwalk (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_fetch(req_fetch), .req_bypass(req_bypass),
        .cfg_ctx_ptr(CTX_PTR), .cfg_ctx_num(CTX_NUM), .cfg_boot(cfg_boot),
        .cfg_prom_base(PROM),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .done(done), .rsp_paddr(rsp_paddr),
        .rsp_size(rsp_size), .rsp_fault(rsp_fault)
    );

    // memory model: accepts on alternate cycles
    assign mem_ready = mem_valid && tog;
    assign mem_rdata = mem[mem_addr[13:2]];
    assign mem_err   = err_on && (mem_addr == err_addr);

    always @(posedge clk) begin
        tog <= ~tog;
        if (mem_valid && mem_ready) begin
            if (mem_write) begin
                wr_cnt       <= wr_cnt + 1;
                last_wr_addr <= mem_addr;
                last_wr_data <= mem_wdata;
            end else begin
                if (rd_cnt == 0) first_rd_addr <= mem_addr;
                rd_cnt       <= rd_cnt + 1;
                last_rd_addr <= mem_addr;
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        err_on = 1'b0;
    endtask

    function automatic logic [35:0] ctx_slot();
        return {CTX_PTR, 4'h0} + {26'h0, CTX_NUM, 2'b00};
    endfunction

    function automatic logic [35:0] slot(input logic [31:0] ptr_desc, input logic [7:0] idx);
        return {ptr_desc[31:2], 2'b00, 4'h0} + {26'h0, idx, 2'b00};
    endfunction

    // level-1 pointer table at 0x2000, level-2 at 0x3000, level-3 at 0x3800
    localparam logic [31:0] P1 = 32'h0000_0201;
    localparam logic [31:0] P2 = 32'h0000_0301;
    localparam logic [31:0] P3 = 32'h0000_0381;

    task automatic setw(input logic [35:0] a, input logic [31:0] d);
        mem[a[13:2]] = d;
    endtask

    task automatic build(input logic [31:0] va, input int depth, input logic [31:0] last);
        setw(ctx_slot(), (depth == 0) ? last : P1);
        if (depth >= 1) setw(slot(P1, va[31:24]), (depth == 1) ? last : P2);
        if (depth >= 2) setw(slot(P2, {2'b00, va[23:18]}), (depth == 2) ? last : P3);
        if (depth >= 3) setw(slot(P3, {2'b00, va[17:12]}), last);
    endtask

    int rd0, wr0;
    task automatic run(input logic [31:0] va, input logic wr, input logic fe, input logic byp);
        @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        req_vaddr = va; req_write = wr; req_fetch = fe; req_bypass = byp;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 200 && !done; k++) @(negedge clk);
        check("R1 done seen", {63'h0, done}, 64'h1);
    endtask

    task automatic t_reset();
        check("R1 reset ready", {63'h0, req_ready}, 64'h1);
        check("R1 reset done", {63'h0, done}, 64'h0);
        check("R11 reset mem_valid", {63'h0, mem_valid}, 64'h0);
        check("R12 reset fault", {54'h0, rsp_fault}, 64'h0);
    endtask

    task automatic t_leaf3_read();
        logic [31:0] va = 32'h0508_3ABC;
        logic [31:0] leaf = 32'h0012_3402;
        clear_mem(); build(va, 3, leaf);
        run(va, 1'b0, 1'b0, 1'b0);
        check("R2 first read addr", {28'h0, first_rd_addr}, {28'h0, ctx_slot()});
        check("R3 four reads", rd_cnt - rd0, 4);
        check("R3 level3 slot", {28'h0, last_rd_addr}, {28'h0, slot(P3, {2'b00, va[17:12]})});
        check("R5 4K paddr", {28'h0, rsp_paddr}, {28'h0, {leaf[31:8], 12'h000} + {24'h0, va[11:0]}});
        check("R5 4K size", {62'h0, rsp_size}, 64'h0);
        check("R12 ok fault", {54'h0, rsp_fault}, 64'h0);
        check("R9 one writeback", wr_cnt - wr0, 1);
        check("R9 wb addr", {28'h0, last_wr_addr}, {28'h0, slot(P3, {2'b00, va[17:12]})});
        check("R9 wb data ref", {32'h0, last_wr_data}, {32'h0, leaf | 32'h20});
        // response held after done
        @(negedge clk); @(negedge clk);
        check("R1 held paddr", {28'h0, rsp_paddr}, {28'h0, {leaf[31:8], 12'h000} + {24'h0, va[11:0]}});
    endtask

    task automatic t_leaf2_write();
        logic [31:0] va = 32'h7AE5_4321;
        logic [31:0] leaf = 32'h00AB_C022;
        clear_mem(); build(va, 2, leaf);
        run(va, 1'b1, 1'b0, 1'b0);
        check("R3 level2 slot", {28'h0, last_rd_addr}, {28'h0, slot(P2, {2'b00, va[23:18]})});
        check("R5 256K paddr", {28'h0, rsp_paddr}, {28'h0, {leaf[31:8], 12'h000} + {18'h0, va[17:0]}});
        check("R5 256K size", {62'h0, rsp_size}, 64'h1);
        check("R9 write sets modified", {32'h0, last_wr_data}, {32'h0, leaf | 32'h60});
        check("R9 one wb", wr_cnt - wr0, 1);
    endtask

    task automatic t_leaf1_clean();
        logic [31:0] va = 32'hC3A5_5A5A;
        logic [31:0] leaf = 32'h0400_0062;
        clear_mem(); build(va, 1, leaf);
        run(va, 1'b1, 1'b0, 1'b0);
        check("R3 level1 slot", {28'h0, last_rd_addr}, {28'h0, slot(P1, va[31:24])});
        check("R4 16M paddr", {28'h0, rsp_paddr}, {28'h0, {leaf[31:8], 12'h000} + {12'h0, va[23:0]}});
        check("R4 16M size", {62'h0, rsp_size}, 64'h2);
        check("R9 no wb when flags set", wr_cnt - wr0, 0);
    endtask

    task automatic t_faults();
        logic [31:0] va = 32'h1234_5678;
        clear_mem(); build(va, 2, 32'h0000_0000);
        run(va, 1'b0, 1'b0, 1'b0);
        check("R6 invalid at level2", {54'h0, rsp_fault}, 64'h204);
        check("R9 no wb on fault", wr_cnt - wr0, 0);
        clear_mem(); build(va, 0, 32'h0000_0000);
        run(va, 1'b0, 1'b0, 1'b0);
        check("R6 invalid at level0", {54'h0, rsp_fault}, 64'h004);
        clear_mem(); build(va, 1, 32'h0000_0003);
        run(va, 1'b0, 1'b0, 1'b0);
        check("R7 reserved at level1", {54'h0, rsp_fault}, 64'h110);
        clear_mem(); build(va, 0, 32'h0000_1002);
        run(va, 1'b0, 1'b0, 1'b0);
        check("R7 leaf in context table", {54'h0, rsp_fault}, 64'h010);
        clear_mem(); build(va, 3, 32'h0000_0201);
        run(va, 1'b0, 1'b0, 1'b0);
        check("R7 pointer at level3", {54'h0, rsp_fault}, 64'h310);
        check("R7 no fifth read", rd_cnt - rd0, 4);
    endtask

    task automatic t_bus_error();
        logic [31:0] va = 32'h0508_3ABC;
        clear_mem(); build(va, 3, 32'h0012_3402);
        err_addr = slot(P2, {2'b00, va[23:18]}); err_on = 1'b1;
        run(va, 1'b0, 1'b0, 1'b0);
        check("R8 bus error level2", {54'h0, rsp_fault}, 64'h210);
        check("R8 reads stop", rd_cnt - rd0, 3);
        check("R8 no write", wr_cnt - wr0, 0);
        err_on = 1'b0;
    endtask

    task automatic t_bypass();
        logic [31:0] va = 32'h1237_5ABC;
        cfg_boot = 1'b0;
        run(va, 1'b0, 1'b1, 1'b1);
        check("R10 plain bypass", {28'h0, rsp_paddr}, {32'h0, va});
        check("R10 no memory", (rd_cnt - rd0) + (wr_cnt - wr0), 0);
        cfg_boot = 1'b1;
        run(va, 1'b0, 1'b1, 1'b1);
        check("R10 boot fetch", {28'h0, rsp_paddr}, {28'h0, PROM | {17'h0, va[18:0]}});
        check("R10 bypass fault", {54'h0, rsp_fault}, 64'h0);
        run(va, 1'b1, 1'b0, 1'b1);
        check("R10 boot data", {28'h0, rsp_paddr}, {32'h0, va});
        cfg_boot = 1'b0;
    endtask

    task automatic t_busy_ignored();
        logic [31:0] va = 32'hC3A5_5A5A;
        logic [31:0] leaf = 32'h0400_0062;
        clear_mem(); build(va, 1, leaf);
        @(negedge clk);
        req_vaddr = va; req_write = 1'b0; req_fetch = 1'b0; req_bypass = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_vaddr = 32'h0000_1FFF; req_bypass = 1'b1;
        check("R1 busy not ready", {63'h0, req_ready}, 64'h0);
        for (int k = 0; k < 200 && !done; k++) @(negedge clk);
        req_valid = 1'b0;
        check("R1 first request result", {28'h0, rsp_paddr},
              {28'h0, {leaf[31:8], 12'h000} + {12'h0, va[23:0]}});
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < 20 && !done; k++) @(negedge clk);
        req_bypass = 1'b0;
    endtask

    initial begin
        #(CLK_P * 60000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_leaf3_read();
        t_leaf2_write();
        t_leaf1_clean();
        t_faults();
        t_bus_error();
        t_bypass();
        t_busy_ignored();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule